// File: doc/BRIEF.md
# Permuted 3D Index Remap Generator

This block turns a flat element number into a remapped element index by treating the elements as a three-dimensional array. The X, Y and Z extents come from one configuration word, together with a 3-bit code that sets the order in which the axes are stepped. After an accepted configuration write, the block walks a nested set of axis counters. It writes one 128-entry table slot per cycle. From then on it answers lookups combinationally: an element number goes in and the remapped index comes out.

In the stepping order, the first axis wraps fastest. When it wraps, it carries into the second axis, and the second carries into the third. Once all three axes have wrapped, the walk simply starts again at zero. Each stored entry is `x + y*X + z*X*Y`, truncated to 8 bits.

A configuration word with an unused order code is rejected. It raises an error flag and changes nothing else. Three offset flags are carried in the configuration word. They are stored and presented at an output, and they play no part in the table.

Top module: `idx_remap_gen`

## Requirements
- R1: After reset, `busy_o`, `cfg_err_o` and `offs_o` are all zero.
- R2: The X, Y and Z size fields sit at `cfg_data_i[6:0]`, `[14:8]` and `[22:16]`. Each field holds its extent minus one, so a field value of 127 gives an extent of 128.
- R3: Table entry n holds `(x + y*X + z*X*Y) mod 256`, where X, Y and Z are the extents and (x, y, z) are the axis counters at step n of the walk. Step 0 is (0,0,0).
- R4: A write with a legal order code raises `busy_o` on the next cycle. `busy_o` stays high for exactly 128 cycles. Every table entry is valid once `busy_o` has fallen.
- R5: The order code at `cfg_data_i[26:24]` selects the stepping order, fastest axis first. Code 0 is XYZ, 1 is XZY, 2 is YXZ, 3 is YZX, 4 is ZXY and 5 is ZYX. The fastest axis steps every entry. On reaching its extent it returns to zero and the next axis in the order steps.
- R6: When all three axes wrap together, the walk continues from (0,0,0). The table therefore repeats with a period of X*Y*Z when that product is below 128.
- R7: A write with code 6 or 7 sets `cfg_err_o` on the next cycle. It does not start a fill, and it leaves the table and `offs_o` unchanged. A write with a legal code clears `cfg_err_o`.
- R8: On a legal write, `offs_o` takes the value {`cfg_data_i[23]`, `cfg_data_i[15]`, `cfg_data_i[7]`} (bit 2 down to bit 0). At all other times `offs_o` holds its value. The offset flags have no effect on the table contents.
- R9: A legal write that arrives while a fill is running restarts the fill from entry 0 with counters at zero. `busy_o` then stays high for 128 cycles counted from the new write.
- R10: While `busy_o` is low, `lk_idx_o` shows the table entry selected by `lk_elem_i` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 32 | Configuration word (sizes, offset flags, order code) |
| lk_elem_i | input | 7 | Element number to look up |
| lk_idx_o | output | 8 | Remapped index for `lk_elem_i` |
| busy_o | output | 1 | Table fill in progress |
| cfg_err_o | output | 1 | Last write carried an unused order code |
| offs_o | output | 3 | Stored offset flags |

## Verification
`busy_o`, `cfg_err_o` and `offs_o` all change on the first clock edge after the write strobe is sampled. `busy_o` then falls on the 128th edge after the write. The lookup output is combinational, so it is due in the same cycle that `lk_elem_i` changes.

The bench's reference model advances on each rising edge using the inputs that were driven on the preceding falling edge. Outputs are compared one time unit after each falling edge, so every comparison sees values that have settled.

Lookups are compared only once the model's own 128-cycle window has run out. This means a fill that ends one cycle early or late shows up as a `busy_o` miscompare rather than being hidden.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int AXES       = 3;
  localparam int LANE       = 8;   // bit stride between size fields
  localparam int OFFS_BIT   = 7;   // offset flag position inside a lane
  localparam int PERM_LSB   = 24;
  localparam int PERM_W     = 3;

  typedef enum logic [PERM_W-1:0] {
    PERM_XYZ = 3'd0,
    PERM_XZY = 3'd1,
    PERM_YXZ = 3'd2,
    PERM_YZX = 3'd3,
    PERM_ZXY = 3'd4,
    PERM_ZYX = 3'd5
  } perm_e;

  typedef logic [AXES-1:0][1:0] order_t;  // [0] = fastest axis

  function automatic logic perm_legal(logic [PERM_W-1:0] code);
    return code <= 3'd5;
  endfunction

  function automatic order_t perm_order(logic [PERM_W-1:0] code);
    order_t o;
    case (code)
      PERM_XZY: o = {2'd1, 2'd2, 2'd0};
      PERM_YXZ: o = {2'd2, 2'd0, 2'd1};
      PERM_YZX: o = {2'd0, 2'd2, 2'd1};
      PERM_ZXY: o = {2'd1, 2'd0, 2'd2};
      PERM_ZYX: o = {2'd0, 2'd1, 2'd2};
      default:  o = {2'd2, 2'd1, 2'd0};
    endcase
    return o;
  endfunction
endpackage

// File: rtl/remap_cfg_dec.sv
module remap_cfg_dec
  import remap_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIM_W = 7
) (
  input  logic [CFG_W-1:0]            cfg_i,
  output logic [AXES-1:0][DIM_W:0]    ext_o,
  output logic [AXES-1:0]             offs_o,
  output logic [PERM_W-1:0]           perm_o,
  output logic                        legal_o
);
  localparam int USED_W = PERM_LSB + PERM_W;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    localparam int LSB = a * LANE;
    assign ext_o[a]  = {1'b0, cfg_i[LSB +: DIM_W]} + {{DIM_W{1'b0}}, 1'b1};
    assign offs_o[a] = cfg_i[LSB + OFFS_BIT];
  end

  assign perm_o  = cfg_i[PERM_LSB +: PERM_W];
  assign legal_o = perm_legal(perm_o);

  logic unused_hi;
  assign unused_hi = ^cfg_i[CFG_W-1:USED_W];
endmodule

// File: rtl/remap_walker.sv
module remap_walker
  import remap_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int DIM_W   = 7,
  parameter int IDX_W   = 8,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [AXES-1:0][DIM_W:0]  ext_i,
  input  logic [PERM_W-1:0]         perm_i,
  output logic                      busy_o,
  output logic                      wr_en_o,
  output logic [PTR_W-1:0]          wr_addr_o,
  output logic [IDX_W-1:0]          wr_data_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic                           busy_q;
  logic [PTR_W-1:0]               ptr_q;
  logic [AXES-1:0][DIM_W-1:0]     cnt_q, cnt_d;
  logic [AXES-1:0][DIM_W:0]       ext_q;
  order_t                         ord_q;

  // carry ripples from fastest axis toward slowest
  always_comb begin
    logic       carry;
    logic [1:0] a;
    cnt_d = cnt_q;
    carry = 1'b1;
    for (int p = 0; p < AXES; p++) begin
      a = ord_q[p];
      if (carry) begin
        if (({1'b0, cnt_q[a]} + {{DIM_W{1'b0}}, 1'b1}) == ext_q[a]) begin
          cnt_d[a] = '0;
        end else begin
          cnt_d[a] = cnt_q[a] + {{(DIM_W-1){1'b0}}, 1'b1};
          carry    = 1'b0;
        end
      end
    end
  end

  for (genvar a = 0; a < AXES; a++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[a] <= '0;
        ext_q[a] <= {{DIM_W{1'b0}}, 1'b1};
      end else if (start_i) begin
        cnt_q[a] <= '0;
        ext_q[a] <= ext_i[a];
      end else if (busy_q) begin
        cnt_q[a] <= cnt_d[a];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      ord_q  <= perm_order(PERM_XYZ);
    end else if (start_i) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      ord_q  <= perm_order(perm_i);
    end else if (busy_q) begin
      ptr_q <= ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
      if (ptr_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign wr_en_o   = busy_q;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = IDX_W'(cnt_q[0])
                   + IDX_W'(cnt_q[1]) * IDX_W'(ext_q[0])
                   + IDX_W'(cnt_q[2]) * IDX_W'(ext_q[0]) * IDX_W'(ext_q[1]);
endmodule

// File: rtl/remap_table.sv
module remap_table #(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = 8,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [IDX_W-1:0]  wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [IDX_W-1:0]  rdata_o
);
  logic [IDX_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/idx_remap_gen.sv
module idx_remap_gen
  import remap_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int DIM_W   = 7,
  parameter int IDX_W   = 8,
  parameter int ENTRIES = 128,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic [PTR_W-1:0]  lk_elem_i,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic              busy_o,
  output logic              cfg_err_o,
  output logic [AXES-1:0]   offs_o
);
  logic [AXES-1:0][DIM_W:0] ext;
  logic [AXES-1:0]          offs;
  logic [PERM_W-1:0]        perm;
  logic                     legal, start;
  logic                     wr_en;
  logic [PTR_W-1:0]         wr_addr;
  logic [IDX_W-1:0]         wr_data;
  logic                     err_q;
  logic [AXES-1:0]          offs_q;

  remap_cfg_dec #(.CFG_W(CFG_W), .DIM_W(DIM_W)) u_dec (
    .cfg_i   (cfg_data_i),
    .ext_o   (ext),
    .offs_o  (offs),
    .perm_o  (perm),
    .legal_o (legal)
  );

  assign start = cfg_we_i & legal;

  remap_walker #(.ENTRIES(ENTRIES), .DIM_W(DIM_W), .IDX_W(IDX_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .ext_i     (ext),
    .perm_i    (perm),
    .busy_o    (busy_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  remap_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tab (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (lk_elem_i),
    .rdata_o (lk_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      offs_q <= '0;
    end else if (cfg_we_i) begin
      err_q <= ~legal;
      if (legal) offs_q <= offs;
    end
  end

  assign cfg_err_o = err_q;
  assign offs_o    = offs_q;
endmodule

// File: rtl/idx_remap_chk.sv
module idx_remap_chk #(
  parameter int ENTRIES = 128,
  localparam int WIN_W  = $clog2(ENTRIES + 1)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [2:0] perm_i,
  input logic [2:0] offs_in_i,
  input logic       busy_o,
  input logic       cfg_err_o,
  input logic [2:0] offs_o
);
  logic             legal_wr, bad_wr;
  logic [WIN_W-1:0] win_q;

  assign legal_wr = cfg_we_i && (perm_i <= 3'd5);
  assign bad_wr   = cfg_we_i && (perm_i > 3'd5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          win_q <= '0;
    else if (legal_wr)    win_q <= WIN_W'(ENTRIES);
    else if (win_q != '0) win_q <= win_q - {{(WIN_W-1){1'b0}}, 1'b1};
  end

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_wr |=> busy_o); // R4
  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (win_q != '0)); // R9
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> cfg_err_o); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_wr |=> !cfg_err_o); // R7
  AST_BAD_NO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_wr && !busy_o) |=> !busy_o); // R7
  AST_OFFS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_wr |=> $stable(offs_o)); // R8
  AST_OFFS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_wr |=> offs_o == $past(offs_in_i)); // R8
endmodule

bind idx_remap_gen idx_remap_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .perm_i    (cfg_data_i[26:24]),
  .offs_in_i ({cfg_data_i[23], cfg_data_i[15], cfg_data_i[7]}),
  .busy_o    (busy_o),
  .cfg_err_o (cfg_err_o),
  .offs_o    (offs_o)
);

// File: tb/test_idx_remap_gen.sv
module test_idx_remap_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_data = '0;
  logic [6:0]  lk_elem = '0;
  logic [7:0]  lk_idx;
  logic        busy, cfg_err;
  logic [2:0]  offs;

  int checks = 0, fails = 0;
  string cur_req = "R3";

  // reference model state
  int         m_win = 0;
  bit         m_err = 0;
  bit [2:0]   m_offs = '0;
  bit         m_loaded = 0;
  int         m_tab  [N];
  int         pend_tab [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_remap_gen i_idx_remap_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
    .lk_elem_i(lk_elem), .lk_idx_o(lk_idx), .busy_o(busy),
    .cfg_err_o(cfg_err), .offs_o(offs)
  );

  // mixed-radix decomposition of the element number
  task automatic build_tab(input int xs, input int ys, input int zs, input int code);
    int lim[3];
    int ord[3];
    int d[3];
    lim[0] = xs; lim[1] = ys; lim[2] = zs;
    case (code)
      0: begin ord[0]=0; ord[1]=1; ord[2]=2; end
      1: begin ord[0]=0; ord[1]=2; ord[2]=1; end
      2: begin ord[0]=1; ord[1]=0; ord[2]=2; end
      3: begin ord[0]=1; ord[1]=2; ord[2]=0; end
      4: begin ord[0]=2; ord[1]=0; ord[2]=1; end
      default: begin ord[0]=2; ord[1]=1; ord[2]=0; end
    endcase
    for (int i = 0; i < N; i++) begin
      int r;
      r = i % (xs * ys * zs);
      d[ord[0]] = r % lim[ord[0]];
      d[ord[1]] = (r / lim[ord[0]]) % lim[ord[1]];
      d[ord[2]] = r / (lim[ord[0]] * lim[ord[1]]);
      pend_tab[i] = (d[0] + d[1] * xs + d[2] * xs * ys) % 256;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_err = 0; m_offs = '0;
    end else begin
      if (cfg_we && cfg_data[26:24] <= 3'd5) begin
        build_tab(int'(cfg_data[6:0]) + 1, int'(cfg_data[14:8]) + 1,
                  int'(cfg_data[22:16]) + 1, int'(cfg_data[26:24]));
        m_win  = N;
        m_err  = 0;
        m_offs = {cfg_data[23], cfg_data[15], cfg_data[7]};
      end else begin
        if (cfg_we) m_err = 1;
        if (m_win > 0) begin
          m_win--;
          if (m_win == 0) begin
            for (int i = 0; i < N; i++) m_tab[i] = pend_tab[i];
            m_loaded = 1;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(busy == (m_win > 0), "R4 busy", busy, m_win > 0);
      chk(cfg_err == m_err, "R7 cfg_err", cfg_err, m_err);
      chk(offs == m_offs, "R8 offs", offs, m_offs);
      if (m_loaded && m_win == 0)
        chk(lk_idx == 8'(m_tab[lk_elem]), {cur_req, " R10 lookup"}, lk_idx, m_tab[lk_elem]);
    end
  end

  function automatic logic [31:0] word(int xf, int yf, int zf, int code, int of);
    logic [31:0] w = '0;
    w[6:0] = 7'(xf); w[14:8] = 7'(yf); w[22:16] = 7'(zf); w[26:24] = 3'(code);
    w[7] = of[0]; w[15] = of[1]; w[23] = of[2];
    return w;
  endfunction

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = ~w;  // junk with strobe low
  endtask

  task automatic sweep();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      lk_elem = 7'(i);
    end
    @(negedge clk);
  endtask

  task automatic fill_and_sweep(input logic [31:0] w);
    cfg_write(w);
    repeat (N + 2) @(negedge clk);
    sweep();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(cfg_err == 0, "R1 err", cfg_err, 0);
    chk(offs == 0, "R1 offs", offs, 0);

    cur_req = "R3";
    fill_and_sweep(word(3, 2, 1, 0, 0));           // 4x3x2, period 24 (R6)
    cur_req = "R5";
    for (int p = 1; p < 6; p++) fill_and_sweep(word(3, 2, 1, p, 0));
    cur_req = "R6";
    fill_and_sweep(word(1, 1, 1, 3, 0));           // 2x2x2
    cur_req = "R2";
    fill_and_sweep(word(9, 12, 127, 5, 0));        // z fastest, extent 128
    fill_and_sweep(word(127, 6, 4, 0, 0));         // x extent 128
    cur_req = "R7";
    cfg_write(word(0, 0, 0, 6, 7));
    sweep();
    cfg_write(word(5, 5, 5, 7, 2));
    sweep();
    cur_req = "R8";
    fill_and_sweep(word(3, 2, 1, 0, 5));           // same table as first case
    cfg_write(word(4, 1, 2, 6, 2));                // bad: offs must hold
    cfg_write(word(4, 1, 2, 2, 0));                // good: clears err, offs to 0
    repeat (N + 2) @(negedge clk);
    sweep();
    cur_req = "R9";
    cfg_write(word(2, 3, 4, 4, 1));
    repeat (40) @(negedge clk);
    cfg_write(word(6, 2, 3, 1, 6));
    repeat (N + 2) @(negedge clk);
    sweep();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule